// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device side of a three-wire serial link made up of an active-high select line, a serial clock and a single bidirectional data line. Each transfer opens with a command byte that picks either the clock register bank or a 31-byte scratchpad RAM, carries a 5-bit address and sets the direction. Data follows one byte at a time, or as a burst when the address field is all ones. All three lines are oversampled in the system clock domain through two-flop synchronizers with edge detection.

The block keeps its own copy of seven timekeeping bytes, a control byte that holds a write-protect flag, a trickle-charge setting byte and the scratchpad. Every byte that is committed also appears for one system cycle on a parallel write port, so the timekeeping counters elsewhere on the chip can load new values. The data line is returned as a value plus an output-enable, which the pad ring combines.

Top module: `tw_reg_slave`

## Requirements
- R1: While the select line is low the output-enable is low and any transfer in progress is abandoned; each rising edge of select starts a fresh command byte, whatever happened before.
- R2: The command byte is: bit 7 write enable (1 = writes allowed), bit 6 bank (0 = clock registers, 1 = RAM), bits 5..1 address, bit 0 direction (0 = write, 1 = read).
- R3: Command and data bits travel least-significant bit first, and incoming bits are sampled on the rising edge of the serial clock.
- R4: Read data is driven on falling edges, starting with the first falling edge after the eighth command bit; the output-enable drops on every rising edge of the serial clock.
- R5: A single-byte write commits exactly one byte; further clock cycles before select falls are ignored.
- R6: During a read, clock cycles after the eighth data bit keep sending bytes while select is high: a single-address read repeats the same byte, a burst read (address 31) steps through the bank from address 0 and wraps to 0 after the last entry (clock bank: 8 entries, addresses 0..7; RAM: 31 entries).
- R7: When the write-protect flag (bit 7 of clock address 7) is 1, every write except a write to clock address 7 itself is discarded, including every byte of a clock burst write.
- R8: A clock burst write commits nothing until all eight bytes (addresses 0..7) have arrived; a burst cut short by select falling leaves every clock register unchanged.
- R9: In a RAM burst write each complete byte is committed at the next address as soon as its eighth bit arrives, so a burst cut short keeps the bytes already completed.
- R10: Clock address 8 holds the trickle-charge byte, outside both burst ranges; the charge-enable output is high only when its bits 7..4 are 1010, bits 3..2 are 01 or 10, and bits 1..0 are not 00.
- R11: Clock addresses 9..30 have no storage: reads return 0x00 and writes are dropped; clock address 7 reads back with bits 6..0 at 0.
- R12: A write command whose bit 7 is 0 changes nothing.
- R13: After reset every register and RAM byte reads 0x00, the output-enable, write strobe and charge-enable are low.
- R14: Each committed byte produces one write-port cycle carrying bank (1 = RAM), address and data; a clock burst write produces eight consecutive cycles with addresses 0 through 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Transfer select line, active high |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Data line as seen at the pad |
| sdo_o | output | 1 | Value to drive onto the data line |
| sdo_oe_o | output | 1 | Output-enable for the data line |
| wr_o | output | 1 | One-cycle strobe for a committed byte |
| wr_ram_o | output | 1 | Bank of the committed byte, 1 = RAM |
| wr_addr_o | output | 5 | Address of the committed byte |
| wr_data_o | output | 8 | Committed byte |
| trickle_on_o | output | 1 | Decoded charge enable from the trickle byte |

## Verification
The assertions rely on the host holding the serial clock and data line steady for several system cycles around each serial clock edge, long enough to cross the two-flop synchronizer, and on select rising while the serial clock is low. The stimulus keeps every serial clock half period at eight system cycles, changes the data line only in the low phase, and raises or lowers select only with the serial clock low, so each serial edge is seen exactly once and the drain of a clock burst finishes long before the next bit arrives.

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int RAM_N  = 31,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  output logic       wr_o,
  output logic       wr_ram_o,
  output logic [4:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       trickle_on_o
);
  localparam logic [4:0] BURST_A  = 5'd31;
  localparam logic [4:0] CTL_A    = 5'd7;
  localparam logic [4:0] TRK_A    = 5'd8;
  localparam logic [4:0] CK_LAST  = 5'd7;
  localparam logic [4:0] RAM_LAST = 5'(RAM_N - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WR, S_RD, S_DONE} ph_t;

  logic [SYNC_N:0]   sck_sh, sel_sh;
  logic [SYNC_N-1:0] sdi_sh;
  logic sck_s, sel_s, din, rise, fall, sel_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sh <= '0;
      sel_sh <= '0;
      sdi_sh <= '0;
    end else begin
      sck_sh <= {sck_sh[SYNC_N-1:0], sck_i};
      sel_sh <= {sel_sh[SYNC_N-1:0], sel_i};
      sdi_sh <= {sdi_sh[SYNC_N-2:0], sdi_i};
    end

  assign sck_s    = sck_sh[SYNC_N-1];
  assign sel_s    = sel_sh[SYNC_N-1];
  assign din      = sdi_sh[SYNC_N-1];
  assign rise     = sck_s & ~sck_sh[SYNC_N];
  assign fall     = ~sck_s & sck_sh[SYNC_N];
  assign sel_rise = sel_s & ~sel_sh[SYNC_N];

  ph_t        ph;
  logic [7:0] sh;
  logic [2:0] bcnt;
  logic [6:0] cmd_q;
  logic [4:0] idx;
  logic       pend_v, pend_ram;
  logic [4:0] pend_a;
  logic [7:0] pend_d;
  logic       dr_act;
  logic [2:0] dr_i;
  logic [7:0] stg [8];
  logic [7:0] tm  [7];
  logic [7:0] mem [RAM_N];
  logic       wp_q;
  logic [7:0] tc_q;

  logic       wen, is_ram, burst;
  logic [4:0] adr, lim, nidx;
  logic [7:0] byte_in;

  assign wen     = cmd_q[6];
  assign is_ram  = cmd_q[5];
  assign adr     = cmd_q[4:0];
  assign burst   = (adr == BURST_A);
  assign lim     = is_ram ? RAM_LAST : CK_LAST;
  assign nidx    = (idx == lim) ? 5'd0 : idx + 5'd1;
  assign byte_in = {din, sh[7:1]};

  function automatic logic [7:0] fetch(input logic ram, input logic [4:0] a);
    if (ram)             return (a <= RAM_LAST) ? mem[a] : 8'h00;
    else if (a < CTL_A)  return tm[a[2:0]];
    else if (a == CTL_A) return {wp_q, 7'h00};
    else if (a == TRK_A) return tc_q;
    else                 return 8'h00;
  endfunction

  function automatic logic wr_ok(input logic en, input logic ram, input logic [4:0] a);
    return en && (ram ? (a <= RAM_LAST) : (a <= TRK_A)) &&
           (!wp_q || (!ram && a == CTL_A));
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph       <= S_IDLE;
      sh       <= '0;
      bcnt     <= '0;
      cmd_q    <= '0;
      idx      <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
      pend_v   <= 1'b0;
      pend_ram <= 1'b0;
      pend_a   <= '0;
      pend_d   <= '0;
      dr_act   <= 1'b0;
      dr_i     <= '0;
    end else begin
      pend_v <= 1'b0;
      if (dr_act) begin
        dr_i <= dr_i + 3'd1;
        if (dr_i == 3'd7) dr_act <= 1'b0;
      end
      if (!sel_s) begin
        ph       <= S_IDLE;
        sdo_oe_o <= 1'b0;
      end else if (sel_rise) begin
        ph       <= S_CMD;
        bcnt     <= '0;
        idx      <= '0;
        sdo_oe_o <= 1'b0;
      end else begin
        if (rise) sdo_oe_o <= 1'b0;
        case (ph)
          S_CMD: if (rise) begin
            sh   <= byte_in;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              cmd_q <= byte_in[7:1];
              if (byte_in[0]) begin
                ph <= S_RD;
                sh <= fetch(byte_in[6], (byte_in[5:1] == BURST_A) ? 5'd0 : byte_in[5:1]);
              end else begin
                ph <= S_WR;
              end
            end
          end
          S_RD: if (fall) begin
            sdo_oe_o <= 1'b1;
            sdo_o    <= sh[0];
            bcnt     <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (burst) idx <= nidx;
              sh <= fetch(is_ram, burst ? nidx : adr);
            end else begin
              sh <= {1'b0, sh[7:1]};
            end
          end
          S_WR: if (rise) begin
            sh   <= byte_in;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (!burst) begin
                pend_v   <= wr_ok(wen, is_ram, adr);
                pend_ram <= is_ram;
                pend_a   <= adr;
                pend_d   <= byte_in;
                ph       <= S_DONE;
              end else if (is_ram) begin
                pend_v   <= wen && !wp_q;
                pend_ram <= 1'b1;
                pend_a   <= idx;
                pend_d   <= byte_in;
                idx      <= idx + 5'd1;
                if (idx == RAM_LAST) ph <= S_DONE;
              end else if (idx == CK_LAST) begin
                dr_act <= wen && !wp_q;
                dr_i   <= '0;
                ph     <= S_DONE;
              end else begin
                idx <= idx + 5'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (sel_s && !sel_rise && ph == S_WR && rise && bcnt == 3'd7 && burst && !is_ram)
      stg[idx[2:0]] <= byte_in;

  assign wr_o      = dr_act | pend_v;
  assign wr_ram_o  = dr_act ? 1'b0 : pend_ram;
  assign wr_addr_o = dr_act ? {2'b00, dr_i} : pend_a;
  assign wr_data_o = dr_act ? stg[dr_i] : pend_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp_q <= 1'b0;
      tc_q <= '0;
      for (int i = 0; i < 7; i++) tm[i] <= '0;
      for (int i = 0; i < RAM_N; i++) mem[i] <= '0;
    end else if (wr_o) begin
      if (wr_ram_o)                mem[wr_addr_o] <= wr_data_o;
      else if (wr_addr_o < CTL_A)  tm[wr_addr_o[2:0]] <= wr_data_o;
      else if (wr_addr_o == CTL_A) wp_q <= wr_data_o[7];
      else                         tc_q <= wr_data_o;
    end

  assign trickle_on_o = (tc_q[7:4] == 4'b1010) &&
                        (tc_q[3:2] == 2'b01 || tc_q[3:2] == 2'b10) &&
                        (tc_q[1:0] != 2'b00);
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int RAM_N = 31
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_s,
  input logic       rise,
  input logic       oe,
  input logic       wr,
  input logic       wram,
  input logic [4:0] wa,
  input logic       wp,
  input logic       trk,
  input logic       dr
);
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sel_s |=> !oe); // R1
  AST_OE_DROP_RISE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !oe); // R4
  AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_n) (wr && !(!wram && wa == 5'd7)) |-> !wp); // R7
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr |-> (wram ? (wa < 5'(RAM_N)) : (wa < 5'd9))); // R11
  AST_TRK_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(trk) |-> $past(wr && !wram && wa == 5'd8)); // R10
  AST_DRAIN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) (dr && wa != 5'd7) |=> (wr && !wram && wa == $past(wa) + 5'd1)); // R14
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.RAM_N(RAM_N)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .sel_s(sel_s),
  .rise (rise),
  .oe   (sdo_oe_o),
  .wr   (wr_o),
  .wram (wr_ram_o),
  .wa   (wr_addr_o),
  .wp   (wp_q),
  .trk  (trickle_on_o),
  .dr   (dr_act)
);

// File: tb/sim_tw_reg_slave.sv
module sim_tw_reg_slave;
  localparam int H = 8;
  localparam int RAM_N = 31;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, oe, wr, wram, trk;
  logic [4:0] wa;
  logic [7:0] wd;

  always #5 clk = ~clk;

  tw_reg_slave #(.RAM_N(RAM_N)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .wr_o(wr), .wr_ram_o(wram),
    .wr_addr_o(wa), .wr_data_o(wd), .trickle_on_o(trk)
  );

  typedef struct packed {logic ram; logic [4:0] a; logic [7:0] d;} item_t;
  item_t expq[$];
  string tagq[$];

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  logic [7:0] m_tm [7];
  logic       m_wp;
  logic [7:0] m_tc;
  logic [7:0] m_ram [RAM_N];
  logic [7:0] cb [8];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(logic ram, logic [4:0] a);
    if (ram)         return (a < 5'(RAM_N)) ? m_ram[a] : 8'h00;
    else if (a < 7)  return m_tm[a[2:0]];
    else if (a == 7) return {m_wp, 7'h00};
    else if (a == 8) return m_tc;
    else             return 8'h00;
  endfunction

  function automatic bit m_ok(bit en, bit ram, logic [4:0] a);
    return en && (ram ? (a < 5'(RAM_N)) : (a <= 5'd8)) && (!m_wp || (!ram && a == 5'd7));
  endfunction

  function automatic bit m_trk();
    return m_tc[7:4] == 4'hA && (m_tc[3:2] == 2'b01 || m_tc[3:2] == 2'b10) && m_tc[1:0] != 2'b00;
  endfunction

  task automatic expect_wr(string tag, bit ram, logic [4:0] a, logic [7:0] d);
    expq.push_back({ram, a, d});
    tagq.push_back(tag);
    if (ram)         m_ram[a] = d;
    else if (a < 7)  m_tm[a[2:0]] = d;
    else if (a == 7) m_wp = d[7];
    else             m_tc = d;
  endtask

  always @(negedge clk) begin
    if (rst_n && wr) begin
      if (expq.size() == 0) begin
        nchk++;
        nerr++;
        $display("FAIL R14 unexpected write: actual ram=%0d addr=%0d data=%0h expected none", wram, wa, wd);
      end else begin
        item_t it;
        string tg;
        it = expq.pop_front();
        tg = tagq.pop_front();
        chk(tg, {31'b0, wram}, {31'b0, it.ram}, "write bank");
        chk(tg, {27'b0, wa}, {27'b0, it.a}, "write addr");
        chk(tg, {24'b0, wd}, {24'b0, it.d}, "write data");
      end
    end
  end

  task automatic begin_x();
    sel = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic end_x();
    sel = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    sdi = b;
    repeat (H) @(negedge clk);
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      repeat (H) @(negedge clk);
      v[i] = sdo;
      chk("R4", {31'b0, oe}, 32'd1, "oe in low phase");
      sck = 1'b1;
      repeat (H) @(negedge clk);
      chk("R4", {31'b0, oe}, 32'd0, "oe after rise");
      sck = 1'b0;
    end
  endtask

  task automatic do_write(string tag, bit en, bit ram, logic [4:0] a, logic [7:0] d, int extra);
    if (m_ok(en, ram, a)) expect_wr(tag, ram, a, d);
    begin_x();
    send_byte({en, ram, a, 1'b0});
    send_byte(d);
    for (int i = 0; i < extra; i++) bit_out(1'b1);
    end_x();
  endtask

  task automatic do_read(string tag, bit ram, logic [4:0] a, int n);
    logic [7:0] v, e;
    int lim;
    lim = ram ? RAM_N : 8;
    begin_x();
    send_byte({1'b1, ram, a, 1'b1});
    for (int k = 0; k < n; k++) begin
      get_byte(v);
      e = (a == 5'd31) ? m_rd(ram, 5'(k % lim)) : m_rd(ram, a);
      chk(tag, {24'b0, v}, {24'b0, e}, "read byte");
    end
    end_x();
  endtask

  task automatic do_ram_burst(string tag, int n, logic [7:0] seed);
    begin_x();
    send_byte({1'b1, 1'b1, 5'd31, 1'b0});
    for (int k = 0; k < n; k++) begin
      if (!m_wp) expect_wr(tag, 1'b1, 5'(k), seed + 8'(k));
      send_byte(seed + 8'(k));
    end
    end_x();
  endtask

  task automatic do_ck_burst(string tag, int n);
    if (n == 8 && !m_wp)
      for (int k = 0; k < 8; k++) expect_wr(tag, 1'b0, 5'(k), cb[k]);
    begin_x();
    send_byte({1'b1, 1'b0, 5'd31, 1'b0});
    for (int k = 0; k < n; k++) send_byte(cb[k]);
    end_x();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) m_tm[i] = 8'h00;
    for (int i = 0; i < RAM_N; i++) m_ram[i] = 8'h00;
    m_wp = 1'b0;
    m_tc = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R13 reset state
    chk("R13", {31'b0, oe}, 32'd0, "oe after reset");
    chk("R13", {31'b0, wr}, 32'd0, "write strobe after reset");
    chk("R13", {31'b0, trk}, 32'd0, "trickle after reset");
    do_read("R13", 1'b0, 5'd31, 9);
    do_read("R13", 1'b1, 5'd4, 1);

    // R2 R3 bank select, LSB-first
    do_write("R2", 1'b1, 1'b0, 5'd3, 8'h45, 0);
    do_write("R2", 1'b1, 1'b1, 5'd3, 8'h9C, 0);
    do_read("R3", 1'b0, 5'd3, 1);
    do_read("R2", 1'b1, 5'd3, 1);

    // R5 extra cycles after single write
    do_write("R5", 1'b1, 1'b1, 5'd5, 8'hA7, 8);
    do_read("R5", 1'b1, 5'd6, 1);
    // R6 single read repeats
    do_read("R6", 1'b1, 5'd5, 2);

    // R12 write disabled
    do_write("R12", 1'b0, 1'b0, 5'd3, 8'h11, 0);
    do_read("R12", 1'b0, 5'd3, 1);

    // R9 RAM burst cut short, R6 burst read
    do_ram_burst("R9", 3, 8'h60);
    do_read("R6", 1'b1, 5'd31, 4);

    // R8 partial clock burst
    cb = '{8'h59, 8'h30, 8'h12, 8'h07, 8'h04, 8'h03, 8'h24, 8'h00};
    do_ck_burst("R8", 5);
    do_read("R8", 1'b0, 5'd0, 1);
    // R8 R14 full clock burst, R6 wrap
    do_ck_burst("R14", 8);
    do_read("R6", 1'b0, 5'd31, 9);

    // R11 control readback, R7 write protect
    do_write("R11", 1'b1, 1'b0, 5'd7, 8'hFF, 0);
    do_read("R11", 1'b0, 5'd7, 1);
    do_write("R7", 1'b1, 1'b0, 5'd1, 8'h11, 0);
    do_write("R7", 1'b1, 1'b1, 5'd3, 8'h22, 0);
    do_write("R7", 1'b1, 1'b0, 5'd8, 8'hA5, 0);
    cb = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h00};
    do_ck_burst("R7", 8);
    do_ram_burst("R7", 2, 8'hC0);
    do_read("R7", 1'b0, 5'd31, 8);
    do_read("R7", 1'b1, 5'd31, 4);
    chk("R7", {31'b0, trk}, 32'd0, "trickle under protect");
    do_write("R7", 1'b1, 1'b0, 5'd7, 8'h00, 0);

    // R10 trickle decode
    do_write("R10", 1'b1, 1'b0, 5'd8, 8'hA5, 0);
    chk("R10", {31'b0, trk}, {31'b0, m_trk()}, "trickle A5");
    do_read("R10", 1'b0, 5'd8, 1);
    do_write("R10", 1'b1, 1'b0, 5'd8, 8'hA4, 0);
    chk("R10", {31'b0, trk}, {31'b0, m_trk()}, "trickle A4");
    do_write("R10", 1'b1, 1'b0, 5'd8, 8'hAD, 0);
    chk("R10", {31'b0, trk}, {31'b0, m_trk()}, "trickle AD");
    do_write("R10", 1'b1, 1'b0, 5'd8, 8'hB6, 0);
    chk("R10", {31'b0, trk}, {31'b0, m_trk()}, "trickle B6");
    do_write("R10", 1'b1, 1'b0, 5'd8, 8'hAB, 0);
    chk("R10", {31'b0, trk}, {31'b0, m_trk()}, "trickle AB");

    // R11 unimplemented address
    do_write("R11", 1'b1, 1'b0, 5'd12, 8'h5A, 0);
    do_read("R11", 1'b0, 5'd12, 1);

    // R1 aborted command then clean transfer
    begin_x();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    end_x();
    do_read("R1", 1'b0, 5'd3, 1);
    // R1 select drop during read
    begin_x();
    send_byte({1'b1, 1'b1, 5'd5, 1'b1});
    repeat (H) @(negedge clk);
    chk("R1", {31'b0, oe}, 32'd1, "oe before drop");
    sel = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1", {31'b0, oe}, 32'd0, "oe after select low");
    repeat (2 * H) @(negedge clk);
    do_write("R1", 1'b1, 1'b1, 5'd9, 8'h3C, 0);
    do_read("R1", 1'b1, 5'd9, 1);

    repeat (50) @(negedge clk);
    chk("R14", expq.size(), 32'd0, "pending expected writes");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule